// File: doc/BRIEF.md
# Dual-Target Serial Slave Address Decoder

This block runs the addressing phase of a two-wire serial slave that hosts two targets: a byte array and a small clock/control register file. A bus front end, outside this block, finds start and stop conditions and samples the data line on each rising clock edge. The decoder takes those events and shifts in the slave byte. It decides whether to acknowledge the byte, picks a target and a direction, and collects a two-byte word address. It also keeps one internal address pointer that advances as data bytes pass.

A random read is built from a dummy write followed by a repeated start. The decoder records that a dummy write happened. It then refuses the read slave byte unless that byte names the same target as the dummy write. The storage, the line drivers and the glitch filters sit around the block and read `ack_req`, `tgt_ccr`, `rd_mode`, `data_phase` and `cur_addr`.

The received bit stream carries a valid strobe only. The decoder can never stall the bus, so it takes every bit in the cycle it is offered and applies no back-pressure. A start and a stop are single-cycle pulses and never arrive together. Every clock of the serial bus yields one `bit_vld` pulse, including the ninth (acknowledge) clock of each byte.

Top module: `dual_tgt_addr_dec`

## Requirements
- R1: After reset `cur_addr` is 0, and `ack_req`, `data_phase`, `rd_mode` and `tgt_ccr` are 0.
- R2: Bits arrive most significant first. A slave byte whose top nibble is 1010 and whose bits 3..1 are 111 raises `ack_req` after its eighth bit, and `tgt_ccr` goes to 0 (array).
- R3: A slave byte with top nibble 1101 and bits 3..1 equal to 111 is acknowledged the same way, and `tgt_ccr` goes to 1 (register file).
- R4: Any other slave byte (another nibble, or select bits other than 111) gets no `ack_req`. Every later bit is ignored until the next start or stop.
- R5: Bit 0 of an acknowledged slave byte sets the direction: 1 drives `rd_mode` to 1 (read), and 0 drives it to 0 (write).
- R6: After a write slave byte, the next two bytes are the word address, high byte first. Both are acknowledged. At the ninth clock of the low byte, the pointer loads the address masked to the target width: 11 bits for the array, 6 bits for the register file.
- R7: In a write, every data byte is acknowledged. The pointer adds one at each data byte's ninth clock and wraps within the selected target's width.
- R8: In a read, `ack_req` stays 0 during the ninth clocks. The pointer adds one at each ninth clock. A 1 sampled there (no acknowledge from the master) ends the transfer: `data_phase` drops and the pointer stops moving.
- R9: A read issued straight after reset, with no word address, starts at address 0.
- R10: A dummy write is a complete word address followed by a start before any data bit. After a dummy write, a read slave byte for the other target is not acknowledged, and one for the same target is. Once a data bit has been written, the next start does not arm this rule.
- R11: A stop returns the decoder to idle. A start at any point restarts slave-byte reception. Bits received while idle change nothing.
- R12: The pointer wraps from 63 to 0 on the register file, in both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | One-cycle pulse: start or repeated start seen on the bus |
| stop_det | input | 1 | One-cycle pulse: stop seen on the bus |
| bit_vld | input | 1 | One-cycle strobe: a bus clock rose and `bit_in` holds the sampled data line |
| bit_in | input | 1 | Sampled data-line value |
| ack_req | output | 1 | Drive an acknowledge during the current ninth clock |
| tgt_ccr | output | 1 | Selected target: 0 array, 1 register file |
| rd_mode | output | 1 | Direction of the last acknowledged slave byte: 1 read |
| data_phase | output | 1 | A data byte transfer is in progress |
| cur_addr | output | PTR_W (11) | Address of the current data byte, masked to the target width |

## Verification
The bench builds the decoder with its default widths: an 11-bit array space and a 6-bit register space. At these widths both wrap points can be reached in a few bytes. Loading 0x7FE and 0x3E or 0x3F exercises the wrap in writes, in reads and on each target. A high address byte of 0xFF shows the masking on load. The cycle-level model follows the same widths, so it covers every dummy-write, mismatch and abort sequence at the address values where the two targets differ.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_AHI, PH_ALO, PH_WDAT, PH_RDAT, PH_HOLD
  } phase_t;

  localparam int BYTE_BITS = 8;
  localparam int WADDR_W   = 16;
endpackage

// File: rtl/sbyte_match.sv
module sbyte_match #(
  parameter logic [3:0] ARR_ID = 4'b1010,
  parameter logic [3:0] CCR_ID = 4'b1101,
  parameter logic [2:0] DSEL   = 3'b111
) (
  input  logic [7:0] sbyte,
  output logic       hit,
  output logic       is_ccr,
  output logic       is_rd
);
  localparam int NTGT = 2;
  localparam logic [NTGT-1:0][3:0] IDS = {CCR_ID, ARR_ID};

  logic [NTGT-1:0] tgt_hit;

  for (genvar g = 0; g < NTGT; g++) begin : g_tgt
    assign tgt_hit[g] = (sbyte[7:4] == IDS[g]) && (sbyte[3:1] == DSEL);
  end

  assign hit    = |tgt_hit;
  assign is_ccr = tgt_hit[1];
  assign is_rd  = sbyte[0];
endmodule

// File: rtl/word_ptr.sv
module word_ptr #(
  parameter int ARR_AW = 11,
  parameter int CCR_AW = 6,
  parameter int PTR_W  = 11,
  parameter int LD_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [LD_W-1:0]  ld_val,
  input  logic             adv,
  input  logic             ccr,
  output logic [PTR_W-1:0] addr_o
);
  localparam logic [PTR_W-1:0] ARR_M = PTR_W'((64'd1 << ARR_AW) - 64'd1);
  localparam logic [PTR_W-1:0] CCR_M = PTR_W'((64'd1 << CCR_AW) - 64'd1);

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] mask;

  if (ARR_AW == CCR_AW) begin : g_same
    assign mask = ARR_M;
  end else begin : g_split
    assign mask = ccr ? CCR_M : ARR_M;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (ld)  ptr <= PTR_W'(ld_val) & mask;
    else if (adv) ptr <= (ptr + 1'b1) & mask;
  end

  assign addr_o = ptr & mask;
endmodule

// File: rtl/dual_tgt_addr_dec.sv
module dual_tgt_addr_dec
  import addr_dec_pkg::*;
#(
  parameter int         ARR_AW = 11,
  parameter int         CCR_AW = 6,
  parameter logic [3:0] ARR_ID = 4'b1010,
  parameter logic [3:0] CCR_ID = 4'b1101,
  parameter logic [2:0] DSEL   = 3'b111,
  localparam int        PTR_W  = (ARR_AW > CCR_AW) ? ARR_AW : CCR_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic             ack_req,
  output logic             tgt_ccr,
  output logic             rd_mode,
  output logic             data_phase,
  output logic [PTR_W-1:0] cur_addr
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] SLOT_CNT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_BITS - 1);

  phase_t           ph;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shreg;
  logic [7:0]       hi_q;
  logic             dev_ok, sel_q, rd_q;
  logic             rr_arm, rr_pend, rr_sel;

  logic [7:0] byte_now;
  logic       m_hit, m_ccr, m_rd, accept;
  logic       slot, live, ptr_ld, ptr_adv;

  assign byte_now = {shreg[6:0], bit_in};
  assign slot     = (bit_cnt == SLOT_CNT);
  assign live     = bit_vld && !start_det && !stop_det &&
                    (ph != PH_IDLE) && (ph != PH_HOLD);

  sbyte_match #(.ARR_ID(ARR_ID), .CCR_ID(CCR_ID), .DSEL(DSEL)) u_match (
    .sbyte (byte_now),
    .hit   (m_hit),
    .is_ccr(m_ccr),
    .is_rd (m_rd)
  );

  // A read after a dummy write must name the same target.
  assign accept = m_hit && !(m_rd && rr_pend && (m_ccr != rr_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      hi_q    <= '0;
      dev_ok  <= 1'b0;
      sel_q   <= 1'b0;
      rd_q    <= 1'b0;
      rr_arm  <= 1'b0;
      rr_pend <= 1'b0;
      rr_sel  <= 1'b0;
    end else if (stop_det) begin
      ph      <= PH_IDLE;
      bit_cnt <= '0;
      rr_arm  <= 1'b0;
      rr_pend <= 1'b0;
    end else if (start_det) begin
      ph      <= PH_DEV;
      bit_cnt <= '0;
      dev_ok  <= 1'b0;
      rr_pend <= (ph == PH_WDAT) && rr_arm;
      rr_sel  <= sel_q;
      rr_arm  <= 1'b0;
    end else if (live) begin
      if (!slot) begin
        shreg   <= byte_now;
        bit_cnt <= bit_cnt + 1'b1;
        if (ph == PH_WDAT) rr_arm <= 1'b0;
        if (ph == PH_DEV && bit_cnt == LAST_CNT) begin
          dev_ok <= accept;
          if (accept) begin
            sel_q <= m_ccr;
            rd_q  <= m_rd;
          end
        end
      end else begin
        bit_cnt <= '0;
        unique case (ph)
          PH_DEV: begin
            rr_pend <= 1'b0;
            if (!dev_ok)   ph <= PH_HOLD;
            else if (rd_q) ph <= PH_RDAT;
            else           ph <= PH_AHI;
          end
          PH_AHI: begin
            hi_q <= shreg;
            ph   <= PH_ALO;
          end
          PH_ALO: begin
            ph     <= PH_WDAT;
            rr_arm <= 1'b1;
          end
          PH_RDAT: if (bit_in) ph <= PH_HOLD;
          default: ;
        endcase
      end
    end
  end

  assign ptr_ld  = live && slot && (ph == PH_ALO);
  assign ptr_adv = live && slot && ((ph == PH_WDAT) || (ph == PH_RDAT));

  word_ptr #(.ARR_AW(ARR_AW), .CCR_AW(CCR_AW), .PTR_W(PTR_W), .LD_W(WADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ptr_ld),
    .ld_val({hi_q, shreg}),
    .adv   (ptr_adv),
    .ccr   (sel_q),
    .addr_o(cur_addr)
  );

  assign ack_req    = slot && ((ph == PH_AHI) || (ph == PH_ALO) || (ph == PH_WDAT) ||
                               ((ph == PH_DEV) && dev_ok));
  assign tgt_ccr    = sel_q;
  assign rd_mode    = rd_q;
  assign data_phase = (ph == PH_WDAT) || (ph == PH_RDAT);
endmodule

// File: rtl/addr_dec_chk.sv
module addr_dec_chk #(
  parameter int ARR_AW = 11,
  parameter int CCR_AW = 6,
  parameter int PTR_W  = 11,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_det,
  input logic             stop_det,
  input logic             bit_vld,
  input logic             ack_req,
  input logic             tgt_ccr,
  input logic             rd_mode,
  input logic             data_phase,
  input logic [PTR_W-1:0] cur_addr,
  input logic [CNT_W-1:0] bit_cnt
);
  localparam logic [PTR_W-1:0] AM = PTR_W'((64'd1 << ARR_AW) - 64'd1);
  localparam logic [PTR_W-1:0] CM = PTR_W'((64'd1 << CCR_AW) - 64'd1);

  logic [PTR_W-1:0] step_exp;
  logic             step_slot;

  assign step_exp  = (cur_addr + 1'b1) & (tgt_ccr ? CM : AM);
  assign step_slot = data_phase && bit_vld && (bit_cnt == CNT_W'(8)) &&
                     !start_det && !stop_det;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cur_addr == '0 && !ack_req && !data_phase));

  a_r8_no_ack_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && rd_mode) |-> !ack_req);

  a_r7_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_slot && !rd_mode) |=> (cur_addr == $past(step_exp)));

  a_r8_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_slot && rd_mode) |=> (cur_addr == $past(step_exp)));

  a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!data_phase && !ack_req));

  a_r11_start_clears_data: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> !data_phase);
endmodule

bind dual_tgt_addr_dec addr_dec_chk #(
  .ARR_AW(ARR_AW), .CCR_AW(CCR_AW), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_det (start_det),
  .stop_det  (stop_det),
  .bit_vld   (bit_vld),
  .ack_req   (ack_req),
  .tgt_ccr   (tgt_ccr),
  .rd_mode   (rd_mode),
  .data_phase(data_phase),
  .cur_addr  (cur_addr),
  .bit_cnt   (bit_cnt)
);

// File: tb/dual_tgt_addr_dec_tb.sv
module dual_tgt_addr_dec_tb;
  localparam time PERIOD = 4ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_det = 1'b0, stop_det = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic ack_req, tgt_ccr, rd_mode, data_phase;
  logic [10:0] cur_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dual_tgt_addr_dec u_dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .bit_vld(bit_vld), .bit_in(bit_in), .ack_req(ack_req), .tgt_ccr(tgt_ccr),
    .rd_mode(rd_mode), .data_phase(data_phase), .cur_addr(cur_addr)
  );

  // Reference model: phases 0 idle, 1 slave byte, 2 addr hi, 3 addr lo,
  // 4 write data, 5 read data, 6 ignore until start/stop.
  int m_ph = 0, m_cnt = 0, m_sh = 0, m_hi = 0, m_ptr = 0;
  int m_ok = 0, m_sel = 0, m_rd = 0, m_arm = 0, m_pend = 0, m_psel = 0;

  function automatic int amask(int c);
    return c ? 63 : 2047;
  endfunction

  function void model_step(bit st, bit sp, bit v, bit b);
    if (sp) begin
      m_ph = 0; m_cnt = 0; m_arm = 0; m_pend = 0;
    end else if (st) begin
      m_pend = (m_ph == 4 && m_arm) ? 1 : 0;
      m_psel = m_sel; m_arm = 0; m_ph = 1; m_cnt = 0; m_ok = 0;
    end else if (v && m_ph != 0 && m_ph != 6) begin
      if (m_cnt < 8) begin
        m_sh = ((m_sh << 1) | int'(b)) & 255;
        if (m_ph == 4) m_arm = 0;
        if (m_ph == 1 && m_cnt == 7) begin
          int nib, ds, r, c;
          nib = m_sh >> 4; ds = (m_sh >> 1) & 7; r = m_sh & 1; c = (nib == 13);
          m_ok = ((nib == 10 || nib == 13) && ds == 7 &&
                  !(r == 1 && m_pend == 1 && c != m_psel)) ? 1 : 0;
          if (m_ok == 1) begin m_sel = c; m_rd = r; end
        end
        m_cnt++;
      end else begin
        m_cnt = 0;
        case (m_ph)
          1: begin m_ph = (m_ok == 0) ? 6 : (m_rd == 1 ? 5 : 2); m_pend = 0; end
          2: begin m_hi = m_sh; m_ph = 3; end
          3: begin m_ptr = ((m_hi << 8) | m_sh) & amask(m_sel); m_ph = 4; m_arm = 1; end
          4: m_ptr = (m_ptr + 1) & amask(m_sel);
          5: begin m_ptr = (m_ptr + 1) & amask(m_sel); if (b) m_ph = 6; end
          default: ;
        endcase
      end
    end
  endfunction

  task automatic compare(string tag);
    int e_ack, e_dp, e_addr;
    e_ack  = (m_cnt == 8 && (m_ph == 2 || m_ph == 3 || m_ph == 4 || (m_ph == 1 && m_ok == 1))) ? 1 : 0;
    e_dp   = (m_ph == 4 || m_ph == 5) ? 1 : 0;
    e_addr = m_ptr & amask(m_sel);
    checks++;
    if (int'(ack_req) != e_ack || int'(data_phase) != e_dp || int'(tgt_ccr) != m_sel ||
        int'(rd_mode) != m_rd || int'(cur_addr) != e_addr) begin
      errors++;
      $display("FAIL %s model: ack/dp/tgt/rd/addr act %0d/%0d/%0d/%0d/%0h exp %0d/%0d/%0d/%0d/%0h",
               tag, ack_req, data_phase, tgt_ccr, rd_mode, cur_addr,
               e_ack, e_dp, m_sel, m_rd, e_addr);
    end
  endtask

  task automatic cyc(bit st, bit sp, bit v, bit b, string tag);
    @(negedge clk);
    start_det = st; stop_det = sp; bit_vld = v; bit_in = b;
    model_step(st, sp, v, b);
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(int v, string tag);
    for (int i = 7; i >= 0; i--) begin
      cyc(0, 0, 1, 1'((v >> i) & 1), tag);
      cyc(0, 0, 0, 0, tag);
    end
  endtask

  task automatic slot(bit b, string tag);
    cyc(0, 0, 1, b, tag);
    cyc(0, 0, 0, 0, tag);
  endtask

  task automatic do_start(string tag); cyc(1, 0, 0, 0, tag); endtask
  task automatic do_stop(string tag);  cyc(0, 1, 0, 0, tag); endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cyc(0, 0, 0, 0, "R1");
    expect_eq("R1 addr", int'(cur_addr), 0);
    expect_eq("R1 ack", int'(ack_req), 0);
    expect_eq("R1 data_phase", int'(data_phase), 0);

    // R9 / R2 / R5 / R8: current-address read of the array from reset
    do_start("R9");
    send_byte(8'hAF, "R2");
    expect_eq("R2 ack", int'(ack_req), 1);
    expect_eq("R2 tgt", int'(tgt_ccr), 0);
    expect_eq("R5 rd", int'(rd_mode), 1);
    slot(0, "R2");
    expect_eq("R9 start addr", int'(cur_addr), 0);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'h5A, "R8");
      expect_eq("R8 no ack", int'(ack_req), 0);
      slot(0, "R8");
    end
    expect_eq("R8 addr after 3", int'(cur_addr), 3);
    send_byte(8'h00, "R8");
    slot(1, "R8");
    expect_eq("R8 nack ends", int'(data_phase), 0);
    send_byte(8'h00, "R8");
    slot(0, "R8");
    expect_eq("R8 frozen", int'(cur_addr), 4);
    do_stop("R11");

    // R6: high address bits masked on load
    do_start("R6");
    send_byte(8'hAE, "R5");
    expect_eq("R5 write dir", int'(rd_mode), 0);
    slot(0, "R6");
    send_byte(8'hFF, "R6");
    expect_eq("R6 hi ack", int'(ack_req), 1);
    slot(0, "R6");
    send_byte(8'h00, "R6");
    slot(0, "R6");
    expect_eq("R6 masked load", int'(cur_addr), 'h700);
    do_stop("R11");

    // R7: write wrap on the array
    do_start("R7");
    send_byte(8'hAE, "R7"); slot(0, "R7");
    send_byte(8'h07, "R7"); slot(0, "R7");
    send_byte(8'hFE, "R7"); slot(0, "R7");
    expect_eq("R6 load", int'(cur_addr), 'h7FE);
    send_byte(8'h11, "R7");
    expect_eq("R7 data ack", int'(ack_req), 1);
    slot(0, "R7");
    send_byte(8'h22, "R7"); slot(0, "R7");
    expect_eq("R7 wrap", int'(cur_addr), 0);
    do_stop("R11");

    // R3 / R12: register file write wrap
    do_start("R3");
    send_byte(8'hDE, "R3");
    expect_eq("R3 ack", int'(ack_req), 1);
    expect_eq("R3 tgt", int'(tgt_ccr), 1);
    slot(0, "R3");
    send_byte(8'h00, "R12"); slot(0, "R12");
    send_byte(8'h3E, "R12"); slot(0, "R12");
    send_byte(8'h01, "R12"); slot(0, "R12");
    send_byte(8'h02, "R12"); slot(0, "R12");
    expect_eq("R12 write wrap", int'(cur_addr), 0);
    do_stop("R11");

    // R10 / R12: matched random read on the register file, read wrap
    do_start("R10");
    send_byte(8'hDE, "R10"); slot(0, "R10");
    send_byte(8'h00, "R10"); slot(0, "R10");
    send_byte(8'h3F, "R10"); slot(0, "R10");
    do_start("R10");
    send_byte(8'hDF, "R10");
    expect_eq("R10 same target ack", int'(ack_req), 1);
    slot(0, "R10");
    send_byte(8'h00, "R12"); slot(0, "R12");
    expect_eq("R12 read wrap", int'(cur_addr), 0);
    send_byte(8'h00, "R12"); slot(1, "R12");
    do_stop("R11");

    // R10: mismatched random read refused
    do_start("R10");
    send_byte(8'hAE, "R10"); slot(0, "R10");
    send_byte(8'h01, "R10"); slot(0, "R10");
    send_byte(8'h23, "R10"); slot(0, "R10");
    do_start("R10");
    send_byte(8'hDF, "R10");
    expect_eq("R10 mismatch nack", int'(ack_req), 0);
    slot(0, "R10");
    expect_eq("R10 no data", int'(data_phase), 0);
    expect_eq("R10 addr kept", int'(cur_addr), 'h123);
    do_stop("R11");

    // R4: bad identifiers
    do_start("R4");
    send_byte(8'h5E, "R4");
    expect_eq("R4 bad nibble", int'(ack_req), 0);
    slot(0, "R4");
    send_byte(8'hAE, "R4");
    expect_eq("R4 ignored after", int'(ack_req), 0);
    expect_eq("R4 no data", int'(data_phase), 0);
    do_stop("R11");
    do_start("R4");
    send_byte(8'hAA, "R4");
    expect_eq("R4 bad select", int'(ack_req), 0);
    do_stop("R11");

    // R11: stop mid address, idle bits ignored, start mid data
    do_start("R11");
    send_byte(8'hAE, "R11"); slot(0, "R11");
    send_byte(8'h02, "R11"); slot(0, "R11");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, "R11");
    do_stop("R11");
    expect_eq("R11 stop idle", int'(data_phase), 0);
    send_byte(8'hAF, "R11");
    expect_eq("R11 idle ignored", int'(ack_req), 0);
    do_start("R11");
    send_byte(8'hAE, "R11"); slot(0, "R11");
    send_byte(8'h00, "R11"); slot(0, "R11");
    send_byte(8'h10, "R11"); slot(0, "R11");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, "R11");
    do_start("R11");
    expect_eq("R11 start aborts", int'(data_phase), 0);
    send_byte(8'hDF, "R10");
    expect_eq("R10 not armed after data", int'(ack_req), 1);
    slot(0, "R10");
    expect_eq("R10 ccr view", int'(cur_addr), 'h10);
    send_byte(8'h00, "R8"); slot(1, "R8");
    do_stop("R11");

    repeat (4) cyc(0, 0, 0, 0, "R11");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule